// File: doc/BRIEF.md
# Preloadable Up/Down Position Counter

This block keeps a wrapping position count that moves on up and down strobes, for example those from a motion sensor that has already been decoded into direction pulses. A rising edge on the up strobe adds one to the count. A rising edge on the down strobe subtracts one. The count can be forced to zero by a clear input in one of two ways. In the immediate form, clearing does not wait for the clock. In the edge-qualified form, the clear takes effect only on a transition of the up strobe while the down strobe is low.

A preload register can be copied into the count, either by an external load pulse or by a command strobe. A latch register takes a snapshot of the count on an external latch pulse. Two reference registers feed equality comparators. Each comparator output can be momentary, tracking equality cycle by cycle, or held, staying set until it is reset.

There are two operating modes. Mode 0 uses only the first comparator. Mode 1 adds the second comparator and the abnormal-input interrupt source. Registers are written through plain parallel ports.

Top module: `updown_pos_counter`

## Requirements
- R1: A rising edge on up_i alone adds one to count_o, and a rising edge on dn_i alone subtracts one. The result shows after that clock edge, and the count wraps modulo 2^CNT_W in both directions. Falling edges do not count.
- R2: Rising edges on up_i and dn_i at the same clock edge leave count_o unchanged. They are recorded as an abnormal input, which is interrupt source bit 2.
- R3: When clr_async_i=1, clr_i=1 forces count_o to 0 at once, without waiting for a clock edge, and holds it at 0 while clr_i stays high.
- R4: When clr_async_i=0, the count becomes 0 at a clock edge where up_i has changed level (rising or falling) since the previous edge, with clr_i=1 and dn_i=0. This clear overrides counting and loading. With clr_i=1 but no up_i transition, the count is not cleared.
- R5: ld_i=1 or cmd_load_i=1 at a clock edge copies the preload value held before that edge into count_o. Loading takes priority over counting. pre_we_i writes pre_d_i into the preload register.
- R6: lt_i=1 at a clock edge copies the count from before that edge into latch_o. Without lt_i, latch_o does not change.
- R7: With hold_i=0, eq_a_o is 1 exactly while count_o equals reference A. eq_n_o[0] is the active-low form of that equality, and eq_n_o[1] is the active-low form for reference B. ref_we_i[0] writes reference A and ref_we_i[1] writes reference B, both from ref_d_i.
- R8: With hold_i=1, a comparator output that has been set stays 1 after the count moves away from the reference. It is cleared by the edge that samples its eq_rst_i bit, or by the edge that samples a change of mode_i.
- R9: With mode_i=0, eq_b_o is 0 and eq_n_o[1] is 1. With mode_i=1, comparator B works the same way as comparator A. eq_or_o is the OR of eq_a_o and eq_b_o.
- R10: An interrupt source becomes pending at a clock edge where its event is present. The events are equality for sources 0 and 1 and abnormal input for source 2. eq_rst_i[k] clears pending source k, and ai_rst_i clears source 2; a reset wins over a new event at the same edge. irq_o is the OR of the pending sources enabled in irq_en_i, and sources 1 and 2 count only in mode 1.
- R11: After reset, count_o, latch_o and the preload and reference registers are 0, and no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Up strobe |
| dn_i | input | 1 | Down strobe |
| clr_i | input | 1 | Zero/clear input |
| clr_async_i | input | 1 | 1: immediate clear, 0: edge-qualified clear |
| ld_i | input | 1 | External load pulse |
| lt_i | input | 1 | External latch pulse |
| cmd_load_i | input | 1 | Command strobe that loads the preload value |
| pre_we_i | input | 1 | Preload register write enable |
| pre_d_i | input | CNT_W | Preload write data |
| ref_we_i | input | 2 | Reference write enables (bit 0 A, bit 1 B) |
| ref_d_i | input | CNT_W | Reference write data |
| hold_i | input | 1 | 1: held comparator outputs, 0: momentary |
| mode_i | input | 1 | Operating mode (0 or 1) |
| eq_rst_i | input | 2 | Comparator reset commands (held output and pending interrupt) |
| ai_rst_i | input | 1 | Abnormal-input interrupt reset command |
| irq_en_i | input | 3 | Interrupt enables (bit 0 A, bit 1 B, bit 2 abnormal input) |
| count_o | output | CNT_W | Counter value |
| latch_o | output | CNT_W | Latch register |
| eq_a_o | output | 1 | Comparator A output |
| eq_b_o | output | 1 | Comparator B output |
| eq_or_o | output | 1 | OR of the comparator outputs |
| eq_n_o | output | 2 | Active-low equality flags |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions check, on every cycle, that:
- an immediate clear keeps the count at zero;
- a load delivers the old preload value;
- the count wraps at the top and stands still on abnormal input;
- the latch holds the previous count;
- a held output does not drop without a reset or mode change;
- comparator B stays silent in mode 0;
- reset commands empty the pending bits.

Only the bench scenarios can show the rest:
- the clear taking effect between clock edges;
- the edge-qualified clear on both the rising and the falling transition;
- the interplay of clear, load and count priority;
- the one-cycle delay of a coincidence interrupt;
- pending abnormal-input state being masked, not lost, when the mode returns to 0.

// File: rtl/updown_pos_pkg.sv
package updown_pos_pkg;
  localparam int NUM_CMP = 2;
  localparam int NUM_IRQ = 3;
  localparam int IRQ_EQA = 0;
  localparam int IRQ_EQB = 1;
  localparam int IRQ_AI  = 2;
endpackage

// File: rtl/updown_pos_core.sv
module updown_pos_core #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         clr_i,
  input  logic         clr_async_i,
  input  logic         load_i,
  input  logic         lt_i,
  input  logic         pre_we_i,
  input  logic [W-1:0] pre_d_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] latch_o,
  output logic         ai_o
);
  logic         up_q, dn_q;
  logic         up_rise, dn_rise, up_edge, sync_clr, clr_now;
  logic [W-1:0] cnt_q, pre_q, latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_i;
      dn_q <= dn_i;
    end
  end

  assign up_rise  = up_i & ~up_q;
  assign dn_rise  = dn_i & ~dn_q;
  assign up_edge  = up_i ^ up_q;
  assign sync_clr = ~clr_async_i & clr_i & ~dn_i & up_edge;
  assign clr_now  = clr_async_i & clr_i;
  assign ai_o     = up_rise & dn_rise;

  // immediate clear acts as an asynchronous reset of the count only
  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_now) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_now)     cnt_q <= '0;
    else if (sync_clr)    cnt_q <= '0;
    else if (load_i)      cnt_q <= pre_q;
    else if (up_rise && !dn_rise) cnt_q <= cnt_q + 1'b1;
    else if (dn_rise && !up_rise) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      latch_q <= '0;
    end else begin
      if (pre_we_i) pre_q   <= pre_d_i;
      if (lt_i)     latch_q <= cnt_q;
    end
  end

  assign cnt_o   = cnt_q;
  assign latch_o = latch_q;

  // R3
  aclr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_now |-> cnt_q == '0);
  // R5
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_now)
    (load_i && !sync_clr) |=> cnt_q == $past(pre_q));
  // R1
  wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_now)
    (up_rise && !dn_rise && !load_i && !sync_clr && cnt_q == '1) |=> cnt_q == '0);
  // R2
  ai_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_now)
    (ai_o && !load_i) |=> $stable(cnt_q));
  // R6
  latch_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lt_i |=> latch_q == $past(cnt_q));
endmodule

// File: rtl/updown_pos_cmp.sv
module updown_pos_cmp #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] cnt_i,
  input  logic         en_i,
  input  logic         hold_i,
  input  logic         clr_i,
  output logic         raw_o,
  output logic         eq_o
);
  logic [W-1:0] ref_q;
  logic         held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      held_q <= 1'b0;
    end else begin
      if (we_i) ref_q <= d_i;
      held_q <= hold_i & ~clr_i & (held_q | raw_o);
    end
  end

  assign raw_o = en_i & (cnt_i == ref_q);
  assign eq_o  = en_i & (raw_o | held_q);

  // R8
  held_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hold_i && $past(rst_ni && hold_i && eq_o && !clr_i)) |-> eq_o);
  // R9
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !eq_o);
endmodule

// File: rtl/updown_pos_irq.sv
module updown_pos_irq
  import updown_pos_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] ev_i,
  input  logic [NUM_IRQ-1:0] rst_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic               mode_i,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] pend_q, eff_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q | ev_i) & ~rst_i;
  end

  always_comb begin
    eff_en          = en_i;
    eff_en[IRQ_EQB] = en_i[IRQ_EQB] & mode_i;
    eff_en[IRQ_AI]  = en_i[IRQ_AI] & mode_i;
  end

  assign irq_o = |(pend_q & eff_en);

  // R10
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rst_i) |=> (pend_q & $past(rst_i)) == '0);
  // R10
  mode0_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !(pend_q[IRQ_EQA] && en_i[IRQ_EQA])) |-> !irq_o);
endmodule

// File: rtl/updown_pos_counter.sv
module updown_pos_counter
  import updown_pos_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             clr_i,
  input  logic             clr_async_i,
  input  logic             ld_i,
  input  logic             lt_i,
  input  logic             cmd_load_i,
  input  logic             pre_we_i,
  input  logic [CNT_W-1:0] pre_d_i,
  input  logic [1:0]       ref_we_i,
  input  logic [CNT_W-1:0] ref_d_i,
  input  logic             hold_i,
  input  logic             mode_i,
  input  logic [1:0]       eq_rst_i,
  input  logic             ai_rst_i,
  input  logic [2:0]       irq_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] latch_o,
  output logic             eq_a_o,
  output logic             eq_b_o,
  output logic             eq_or_o,
  output logic [1:0]       eq_n_o,
  output logic             irq_o
);
  logic [CNT_W-1:0]   cnt;
  logic               ai, mode_q, mode_chg;
  logic [NUM_CMP-1:0] raw, eq, cmp_en;

  updown_pos_core #(.W(CNT_W)) u_core (
    .clk_i, .rst_ni, .up_i, .dn_i, .clr_i, .clr_async_i,
    .load_i(ld_i | cmd_load_i), .lt_i, .pre_we_i, .pre_d_i,
    .cnt_o(cnt), .latch_o, .ai_o(ai)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_i;
  end
  assign mode_chg = mode_i ^ mode_q;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign cmp_en[k] = (k == 0) ? 1'b1 : mode_i;
    updown_pos_cmp #(.W(CNT_W)) u_cmp (
      .clk_i, .rst_ni, .we_i(ref_we_i[k]), .d_i(ref_d_i), .cnt_i(cnt),
      .en_i(cmp_en[k]), .hold_i, .clr_i(eq_rst_i[k] | mode_chg),
      .raw_o(raw[k]), .eq_o(eq[k])
    );
  end

  updown_pos_irq u_irq (
    .clk_i, .rst_ni,
    .ev_i({ai, raw[1], raw[0]}),
    .rst_i({ai_rst_i, eq_rst_i[1], eq_rst_i[0]}),
    .en_i(irq_en_i), .mode_i, .irq_o
  );

  assign count_o = cnt;
  assign eq_a_o  = eq[0];
  assign eq_b_o  = eq[1];
  assign eq_or_o = |eq;
  assign eq_n_o  = ~raw;
endmodule

// File: tb/updown_pos_counter_test.sv
module updown_pos_counter_test;
  localparam int W = 24;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic up_i = 0, dn_i = 0, clr_i = 0, clr_async_i = 0, ld_i = 0, lt_i = 0, cmd_load_i = 0;
  logic pre_we_i = 0, hold_i = 0, mode_i = 0, ai_rst_i = 0;
  logic [W-1:0] pre_d_i = '0, ref_d_i = '0;
  logic [1:0] ref_we_i = '0, eq_rst_i = '0;
  logic [2:0] irq_en_i = '0;
  logic [W-1:0] count_o, latch_o;
  logic eq_a_o, eq_b_o, eq_or_o, irq_o;
  logic [1:0] eq_n_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  updown_pos_counter #(.CNT_W(W)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk_i); endtask

  task automatic pulse_up(); up_i = 1; tick(); up_i = 0; tick(); endtask
  task automatic pulse_dn(); dn_i = 1; tick(); dn_i = 0; tick(); endtask

  task automatic set_count(input logic [W-1:0] v);
    pre_d_i = v; pre_we_i = 1; tick(); pre_we_i = 0;
    cmd_load_i = 1; tick(); cmd_load_i = 0;
  endtask

  task automatic t_reset();
    chk("R11 count", count_o, 0);
    chk("R11 latch", latch_o, 0);
    chk("R11 irq", irq_o, 0);
    chk("R11 eq_n", eq_n_o, 2'b10);
  endtask

  task automatic t_count();
    pulse_up(); pulse_up(); pulse_up();
    chk("R1 up x3", count_o, 3);
    pulse_dn();
    chk("R1 down", count_o, 2);
    set_count('1);
    chk("R5 cmd load", count_o, 24'hffffff);
    pulse_up();
    chk("R1 wrap up", count_o, 0);
    pulse_dn();
    chk("R1 wrap down", count_o, 24'hffffff);
  endtask

  task automatic t_abnormal();
    set_count(24'd100);
    up_i = 1; dn_i = 1; tick(); up_i = 0; dn_i = 0;
    chk("R2 both edges", count_o, 100);
    tick();
  endtask

  task automatic t_load_latch();
    pre_d_i = 24'd40; pre_we_i = 1; tick(); pre_we_i = 0;
    ld_i = 1; up_i = 1; tick(); ld_i = 0; up_i = 0;
    chk("R5 load over count", count_o, 40);
    tick();
    lt_i = 1; tick(); lt_i = 0;
    chk("R6 latch", latch_o, 40);
    pulse_up();
    chk("R6 latch kept", latch_o, 40);
  endtask

  task automatic t_clear();
    set_count(24'd9);
    clr_async_i = 1; clr_i = 1;
    #1;
    chk("R3 immediate clear", count_o, 0);
    tick(); pulse_up();
    chk("R3 clear held", count_o, 0);
    clr_i = 0; clr_async_i = 0; tick();
    set_count(24'd9);
    clr_i = 1; tick();
    chk("R4 no edge no clear", count_o, 9);
    up_i = 1; tick();
    chk("R4 rise clear", count_o, 0);
    clr_i = 0; up_i = 0; tick();
    up_i = 1; tick();
    chk("R4 count after", count_o, 1);
    clr_i = 1; up_i = 0; tick();
    chk("R4 fall clear", count_o, 0);
    clr_i = 0; tick();
  endtask

  task automatic t_compare();
    ref_d_i = 24'd5; ref_we_i = 2'b01; tick();
    ref_d_i = 24'd7; ref_we_i = 2'b10; tick(); ref_we_i = 0;
    set_count(24'd4);
    chk("R7 not equal", eq_a_o, 0);
    pulse_up();
    chk("R7 equal", eq_a_o, 1);
    chk("R7 flag low", eq_n_o[0], 0);
    pulse_up();
    chk("R7 momentary drop", eq_a_o, 0);
    hold_i = 1;
    set_count(24'd5); pulse_up();
    chk("R8 held", eq_a_o, 1);
    chk("R8 flag raw", eq_n_o[0], 1);
    eq_rst_i = 2'b01; tick(); eq_rst_i = 0;
    chk("R8 held reset", eq_a_o, 0);
    set_count(24'd7);
    chk("R9 B off mode0", eq_b_o, 0);
    chk("R9 B flag mode0", eq_n_o[1], 1);
    mode_i = 1; tick(); tick();
    chk("R9 B on mode1", eq_b_o, 1);
    chk("R9 or", eq_or_o, 1);
    chk("R9 B flag", eq_n_o[1], 0);
    set_count(24'd5); pulse_up();
    chk("R8 A held mode1", eq_a_o, 1);
    mode_i = 0; tick();
    chk("R8 mode change clears", eq_a_o, 0);
    hold_i = 0; tick();
  endtask

  task automatic t_irq();
    set_count(24'd10);
    eq_rst_i = 2'b11; ai_rst_i = 1; tick(); eq_rst_i = 0; ai_rst_i = 0;
    irq_en_i = 3'b001; tick();
    chk("R10 idle", irq_o, 0);
    set_count(24'd5);
    chk("R10 not yet", irq_o, 0);
    tick();
    chk("R10 eq irq", irq_o, 1);
    set_count(24'd10);
    chk("R10 pending stays", irq_o, 1);
    eq_rst_i = 2'b01; tick(); eq_rst_i = 0;
    chk("R10 eq reset", irq_o, 0);
    irq_en_i = 3'b100;
    up_i = 1; dn_i = 1; tick(); up_i = 0; dn_i = 0;
    chk("R10 ai masked mode0", irq_o, 0);
    mode_i = 1; tick();
    chk("R10 ai mode1", irq_o, 1);
    mode_i = 0; tick();
    chk("R10 ai masked again", irq_o, 0);
    mode_i = 1; ai_rst_i = 1; tick(); ai_rst_i = 0;
    chk("R10 ai reset", irq_o, 0);
    mode_i = 0; irq_en_i = 0; tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1; tick();
    t_reset();
    t_count();
    t_abnormal();
    t_load_latch();
    t_clear();
    t_compare();
    t_irq();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule